// File: doc/BRIEF.md
# Partitioned CAM/RAM Word Array

This block is a small content-addressable memory whose every entry carries a 64-bit word and two status bits: skip and empty. A 3-bit partition code divides each word into a searchable part and a stored-only part in 16-bit segments. The stored-only part can sit at either the low end or the high end of the word. Stored-only bits are kept and read back like any other bits, but a search never looks at them.

A search compares a comparand against every live entry. An entry is live when it is neither empty nor skipped. The search registers a hit flag and the address of the lowest-indexed matching entry. The array also tracks the lowest empty entry as the next-free address and raises a full flag when no entry is empty.

Direct writes and reads can take their address from four places: an explicit input, an internal address register, the next-free address, or the registered match address. A write can be masked by either of two loadable mask registers. Instruction decoding and any external bus protocol belong to the surrounding logic.

Top module: `cam_ram_array`

## Requirements
- R1: After reset every entry is empty, every skip bit is clear and all stored words are zero. The outputs read full=0, nf_addr=0, match_hit=0, match_addr=0 and rd_ok=0.
- R2: A search takes one cycle. With cmp_en high at a clock edge, match_hit and match_addr are updated at that edge. match_addr is the lowest index of all live entries whose searchable bits equal cmp_data. When no live entry matches, match_hit=0 and match_addr=0.
- R3: The split_code decides which bits are searched. Bit 2 gives the side that is stored-only: 0 means the low end and 1 means the high end. Bits 1:0 give the number of 16-bit stored-only segments. For example, 001 searches bits 63:16, 101 searches bits 47:0, 011 searches bits 63:48 and 111 searches bits 15:0. Codes 000 and 100 search the whole word.
- R4: match_hit and match_addr keep their values until the next search, whatever writes take place in between.
- R5: Skipped entries and empty entries never match. stat_wr loads stat_skip and stat_empty into the entry at stat_addr.
- R6: nf_addr is the lowest index whose empty bit is set, and full is high when no entry is empty. Both reflect the state registered at the previous edge.
- R7: wr_src selects the write address: 0 uses wr_addr, 1 uses the address register (loaded by areg_wr), 2 uses nf_addr and 3 uses match_addr. A write stores the data and clears the entry's empty bit.
- R8: wr_msk selects the write mask: 0 and 3 mean no mask, 1 means mask A and 2 means mask B. msk_wr loads mask A when msk_sel=0 and mask B when msk_sel=1. A mask bit of 1 keeps the old stored bit.
- R9: A write is ignored, leaving every entry unchanged, when wr_src=2 while full is high, or when wr_src=3 while match_hit is low.
- R10: rd_en with rd_src (encoded like wr_src) returns the addressed word on rd_data, with rd_ok=1, in the next cycle. When the source has no valid address (rd_src=2 while full, or rd_src=3 without a hit), rd_ok=0 and rd_data=0.
- R11: A search in the same cycle as a write sees the array contents as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| split_code | input | 3 | Searchable/stored-only partition code |
| msk_wr | input | 1 | Load a mask register |
| msk_sel | input | 1 | Mask to load: 0 selects A, 1 selects B |
| msk_wdata | input | 64 | Mask value to load |
| areg_wr | input | 1 | Load the address register |
| areg_wdata | input | AW | Address register value |
| stat_wr | input | 1 | Load the status bits of one entry |
| stat_addr | input | AW | Entry whose status bits are loaded |
| stat_skip | input | 1 | New skip bit |
| stat_empty | input | 1 | New empty bit |
| wr_en | input | 1 | Write strobe |
| wr_src | input | 2 | Write address source |
| wr_addr | input | AW | Explicit write address |
| wr_msk | input | 2 | Write mask select |
| wr_data | input | 64 | Write data |
| cmp_en | input | 1 | Search strobe |
| cmp_data | input | 64 | Comparand |
| rd_en | input | 1 | Read strobe |
| rd_src | input | 2 | Read address source |
| rd_addr | input | AW | Explicit read address |
| match_hit | output | 1 | Last search found a match |
| match_addr | output | AW | Highest-priority match address |
| nf_addr | output | AW | Next-free address |
| full | output | 1 | No entry is empty |
| rd_data | output | 64 | Read data |
| rd_ok | output | 1 | Read data valid |

## Verification
The bench places the same comparand in two entries, then skips the lower one and empties the upper one. A design with the priority reversed would report the wrong address, and one that ignores a status bit would hit where it must miss. It also sweeps the partition codes with comparands that differ only in the stored-only segments, so a mask built on the wrong side or with the wrong segment count turns an expected hit into a miss. Three further cases are covered:
- Writes through the next-free or match address are driven when that address does not exist. A design that falls back to entry 0 would corrupt that entry or clear its empty bit.
- A search is issued in the same cycle as a write. A design that forwards the new data would report a premature hit.
- Both masks are exercised. A mask with inverted polarity would overwrite the protected bits.

// File: rtl/cam_pkg.sv
package cam_pkg;

    localparam int WORD_W = 64;
    localparam int SEG_W  = 16;

    typedef enum logic [1:0] {
        SRC_DIRECT = 2'd0,
        SRC_AREG   = 2'd1,
        SRC_NFREE  = 2'd2,
        SRC_MATCH  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        MSK_NONE  = 2'd0,
        MSK_A     = 2'd1,
        MSK_B     = 2'd2,
        MSK_NONE2 = 2'd3
    } msel_e;

    // Searchable-bit mask: code[2] picks the stored-only side (0 = low end),
    // code[1:0] counts stored-only segments.
    function automatic logic [WORD_W-1:0] care_mask(input logic [2:0] code);
        logic [WORD_W-1:0] ones;
        int unsigned       sh;
        ones = '1;
        sh   = 32'(code[1:0]) * SEG_W;
        return code[2] ? (ones >> sh) : (ones << sh);
    endfunction

endpackage

// File: rtl/cam_match_vec.sv
module cam_match_vec #(
    parameter int DEPTH = 16,
    parameter int W     = 64
) (
    input  logic [DEPTH-1:0][W-1:0] mem,
    input  logic [DEPTH-1:0]        empty,
    input  logic [DEPTH-1:0]        skip,
    input  logic [W-1:0]            key,
    input  logic [W-1:0]            care,
    output logic [DEPTH-1:0]        hit
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign hit[i] = !empty[i] && !skip[i] && (((mem[i] ^ key) & care) == '0);
    end

endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
    parameter int N  = 16,
    parameter int AW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [AW-1:0] idx
);

    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = AW'(i);
            end
        end
    end

endmodule

// File: rtl/cam_ram_array.sv
module cam_ram_array
    import cam_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    split_code,
    input  logic          msk_wr,
    input  logic          msk_sel,
    input  logic [W-1:0]  msk_wdata,
    input  logic          areg_wr,
    input  logic [AW-1:0] areg_wdata,
    input  logic          stat_wr,
    input  logic [AW-1:0] stat_addr,
    input  logic          stat_skip,
    input  logic          stat_empty,
    input  logic          wr_en,
    input  logic [1:0]    wr_src,
    input  logic [AW-1:0] wr_addr,
    input  logic [1:0]    wr_msk,
    input  logic [W-1:0]  wr_data,
    input  logic          cmp_en,
    input  logic [W-1:0]  cmp_data,
    input  logic          rd_en,
    input  logic [1:0]    rd_src,
    input  logic [AW-1:0] rd_addr,
    output logic          match_hit,
    output logic [AW-1:0] match_addr,
    output logic [AW-1:0] nf_addr,
    output logic          full,
    output logic [W-1:0]  rd_data,
    output logic          rd_ok
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [DEPTH-1:0]        empty;
        logic [DEPTH-1:0]        skip;
        logic [W-1:0]            mska;
        logic [W-1:0]            mskb;
        logic [AW-1:0]           areg;
        logic                    mhit;
        logic [AW-1:0]           maddr;
        logic [W-1:0]            rdat;
        logic                    rok;
    } st_t;

    st_t s_q, s_d, rst_val;

    logic [W-1:0]     care;
    logic [DEPTH-1:0] hit_vec;
    logic             cmp_found;
    logic [AW-1:0]    cmp_idx;
    logic             nf_found;
    logic [AW-1:0]    nf_idx;
    logic             wr_ok;
    logic [AW-1:0]    wr_tgt;
    logic             rd_okv;
    logic [AW-1:0]    rd_tgt;
    logic [W-1:0]     keep;

    assign care = care_mask(split_code);

    cam_match_vec #(.DEPTH(DEPTH), .W(W)) u_match (
        .mem   (s_q.mem),
        .empty (s_q.empty),
        .skip  (s_q.skip),
        .key   (cmp_data),
        .care  (care),
        .hit   (hit_vec)
    );

    cam_prio_enc #(.N(DEPTH), .AW(AW)) u_hit_enc (
        .req   (hit_vec),
        .found (cmp_found),
        .idx   (cmp_idx)
    );

    cam_prio_enc #(.N(DEPTH), .AW(AW)) u_free_enc (
        .req   (s_q.empty),
        .found (nf_found),
        .idx   (nf_idx)
    );

    // Address resolution for the write port.
    always_comb begin
        wr_ok  = 1'b1;
        wr_tgt = wr_addr;
        case (wr_src)
            SRC_AREG:  wr_tgt = s_q.areg;
            SRC_NFREE: begin wr_ok = nf_found; wr_tgt = nf_idx;    end
            SRC_MATCH: begin wr_ok = s_q.mhit; wr_tgt = s_q.maddr; end
            default:   wr_tgt = wr_addr;
        endcase
    end

    // Address resolution for the read port.
    always_comb begin
        rd_okv = 1'b1;
        rd_tgt = rd_addr;
        case (rd_src)
            SRC_AREG:  rd_tgt = s_q.areg;
            SRC_NFREE: begin rd_okv = nf_found; rd_tgt = nf_idx;    end
            SRC_MATCH: begin rd_okv = s_q.mhit; rd_tgt = s_q.maddr; end
            default:   rd_tgt = rd_addr;
        endcase
    end

    always_comb begin
        case (wr_msk)
            MSK_A:   keep = s_q.mska;
            MSK_B:   keep = s_q.mskb;
            default: keep = '0;
        endcase
    end

    always_comb begin
        rst_val       = '0;
        rst_val.empty = '1;
    end

    // Next-state computation.
    always_comb begin
        s_d = s_q;
        if (msk_wr) begin
            if (msk_sel) s_d.mskb = msk_wdata;
            else         s_d.mska = msk_wdata;
        end
        if (areg_wr) begin
            s_d.areg = areg_wdata;
        end
        if (cmp_en) begin
            s_d.mhit  = cmp_found;
            s_d.maddr = cmp_found ? cmp_idx : '0;
        end
        if (stat_wr) begin
            s_d.skip[stat_addr]  = stat_skip;
            s_d.empty[stat_addr] = stat_empty;
        end
        if (wr_en && wr_ok) begin
            s_d.mem[wr_tgt]   = (s_q.mem[wr_tgt] & keep) | (wr_data & ~keep);
            s_d.empty[wr_tgt] = 1'b0;
        end
        s_d.rok = 1'b0;
        if (rd_en) begin
            s_d.rok  = rd_okv;
            s_d.rdat = rd_okv ? s_q.mem[rd_tgt] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= rst_val;
        else        s_q <= s_d;
    end

    assign match_hit  = s_q.mhit;
    assign match_addr = s_q.maddr;
    assign nf_addr    = nf_idx;
    assign full       = !nf_found;
    assign rd_data    = s_q.rdat;
    assign rd_ok      = s_q.rok;

endmodule

// File: rtl/cam_ram_array_chk.sv
module cam_ram_array_chk #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int W     = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stat_wr,
    input logic          wr_en,
    input logic [1:0]    wr_src,
    input logic          cmp_en,
    input logic          rd_en,
    input logic [1:0]    rd_src,
    input logic          match_hit,
    input logic [AW-1:0] match_addr,
    input logic [AW-1:0] nf_addr,
    input logic          full,
    input logic [W-1:0]  rd_data,
    input logic          rd_ok
);

    // R1: state seen at the first edge after reset is the cleared state
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!full && nf_addr == '0 && !match_hit && match_addr == '0 && !rd_ok));

    // R4: match result holds without a search
    a_r4_match_held: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> ($stable(match_hit) && $stable(match_addr)));

    // R6: a write through the next-free address moves the pointer or fills the array
    a_r6_nf_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_src == 2'd2 && !full && !stat_wr) |=> (full || nf_addr != $past(nf_addr)));

    // R9: next-free write while full leaves the array full
    a_r9_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_src == 2'd2 && full && !stat_wr) |=> full);

    // R9: match write without a hit changes no empty bit
    a_r9_nohit_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_src == 2'd3 && !match_hit && !stat_wr) |=> ($stable(full) && $stable(nf_addr)));

    // R10: read through a missing match address returns nothing
    a_r10_read_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_src == 2'd3 && !match_hit) |=> (!rd_ok && rd_data == '0));

endmodule

bind cam_ram_array cam_ram_array_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_cam_ram_array.sv
module sim_cam_ram_array;

    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [2:0]    split_code;
    logic          msk_wr, msk_sel;
    logic [63:0]   msk_wdata;
    logic          areg_wr;
    logic [AW-1:0] areg_wdata;
    logic          stat_wr;
    logic [AW-1:0] stat_addr;
    logic          stat_skip, stat_empty;
    logic          wr_en;
    logic [1:0]    wr_src;
    logic [AW-1:0] wr_addr;
    logic [1:0]    wr_msk;
    logic [63:0]   wr_data;
    logic          cmp_en;
    logic [63:0]   cmp_data;
    logic          rd_en;
    logic [1:0]    rd_src;
    logic [AW-1:0] rd_addr;
    logic          match_hit;
    logic [AW-1:0] match_addr;
    logic [AW-1:0] nf_addr;
    logic          full;
    logic [63:0]   rd_data;
    logic          rd_ok;

    int n_chk  = 0;
    int n_fail = 0;

    localparam logic [63:0] KX = 64'hDEAD_BEEF_0000_1234;
    localparam logic [63:0] KY = 64'h0BAD_F00D_5555_AAAA;
    localparam logic [63:0] KP = 64'h1111_2222_3333_4444;

    cam_ram_array #(.DEPTH(DEPTH)) u0 (.*);

    always #10 clk = ~clk;

    task automatic idle();
        msk_wr = 0; msk_sel = 0; msk_wdata = '0;
        areg_wr = 0; areg_wdata = '0;
        stat_wr = 0; stat_addr = '0; stat_skip = 0; stat_empty = 0;
        wr_en = 0; wr_src = 0; wr_addr = '0; wr_msk = 0; wr_data = '0;
        cmp_en = 0; cmp_data = '0;
        rd_en = 0; rd_src = 0; rd_addr = '0;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        split_code = 3'b000;
        idle();
        @(negedge clk);
        cyc();
        cyc();
        rst_n = 1;
    endtask

    task automatic wr(input logic [1:0] src, input logic [AW-1:0] a, input logic [63:0] d, input logic [1:0] m);
        wr_en = 1; wr_src = src; wr_addr = a; wr_data = d; wr_msk = m;
        cyc();
    endtask

    task automatic search(input logic [63:0] k);
        cmp_en = 1; cmp_data = k;
        cyc();
    endtask

    task automatic rd(input logic [1:0] src, input logic [AW-1:0] a);
        rd_en = 1; rd_src = src; rd_addr = a;
        cyc();
    endtask

    task automatic stat(input logic [AW-1:0] a, input logic sk, input logic em);
        stat_wr = 1; stat_addr = a; stat_skip = sk; stat_empty = em;
        cyc();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "full", 64'(full), 64'd0);
        chk("R1", "nf_addr", 64'(nf_addr), 64'd0);
        chk("R1", "match_hit", 64'(match_hit), 64'd0);
        chk("R1", "rd_ok", 64'(rd_ok), 64'd0);
        rd(2'd0, 4'd5);
        chk("R1", "word 5 after reset", rd_data, 64'd0);
        chk("R10", "direct read ok", 64'(rd_ok), 64'd1);
    endtask

    task automatic t_fill();
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            chk("R6", "nf_addr during fill", 64'(nf_addr), 64'(i));
            wr(2'd2, 4'd0, 64'h1000 + 64'(i), 2'd0);
        end
        chk("R6", "full after fill", 64'(full), 64'd1);
        wr(2'd2, 4'd0, 64'hBAD, 2'd0);
        rd(2'd0, 4'd0);
        chk("R9", "entry 0 after write while full", rd_data, 64'h1000);
        rd(2'd0, 4'd15);
        chk("R7", "entry 15 via next-free", rd_data, 64'h100F);
        rd(2'd2, 4'd0);
        chk("R10", "next-free read while full ok", 64'(rd_ok), 64'd0);
        chk("R10", "next-free read while full data", rd_data, 64'd0);
        stat(4'd5, 1'b0, 1'b1);
        chk("R6", "nf_addr after freeing 5", 64'(nf_addr), 64'd5);
        chk("R6", "full after freeing 5", 64'(full), 64'd0);
    endtask

    task automatic t_priority();
        do_reset();
        wr(2'd0, 4'd3, KX, 2'd0);
        wr(2'd0, 4'd9, KX, 2'd0);
        wr(2'd0, 4'd1, KY, 2'd0);
        search(KX);
        chk("R2", "hit two copies", 64'(match_hit), 64'd1);
        chk("R2", "lowest copy wins", 64'(match_addr), 64'd3);
        stat(4'd3, 1'b1, 1'b0);
        search(KX);
        chk("R5", "skipped entry passed over", 64'(match_addr), 64'd9);
        stat(4'd9, 1'b0, 1'b1);
        search(KX);
        chk("R5", "empty entry no hit", 64'(match_hit), 64'd0);
        chk("R2", "miss address zero", 64'(match_addr), 64'd0);
        search(KY);
        chk("R2", "second key hit addr", 64'(match_addr), 64'd1);
        search(64'd0);
        chk("R5", "empty zero words no hit", 64'(match_hit), 64'd0);
    endtask

    task automatic split_case(input logic [2:0] code, input logic [63:0] k, input logic exp);
        split_code = code;
        search(k);
        chk("R3", $sformatf("code %b hit", code), 64'(match_hit), 64'(exp));
        if (exp) chk("R3", $sformatf("code %b addr", code), 64'(match_addr), 64'd2);
    endtask

    task automatic t_split();
        do_reset();
        wr(2'd0, 4'd2, KP, 2'd0);
        split_case(3'b000, 64'h1111_2222_3333_FFFF, 1'b0);
        split_case(3'b001, 64'h1111_2222_3333_FFFF, 1'b1);
        split_case(3'b001, 64'hFFFF_2222_3333_4444, 1'b0);
        split_case(3'b101, 64'hFFFF_2222_3333_4444, 1'b1);
        split_case(3'b010, 64'h1111_2222_0000_0000, 1'b1);
        split_case(3'b110, 64'h0000_0000_3333_4444, 1'b1);
        split_case(3'b011, 64'h1111_0000_0000_0000, 1'b1);
        split_case(3'b111, 64'h0000_0000_0000_4444, 1'b1);
        split_case(3'b111, 64'h0000_0000_0000_4445, 1'b0);
        split_case(3'b100, 64'h1111_2222_3333_FFFF, 1'b0);
        split_case(3'b100, KP, 1'b1);
        split_code = 3'b000;
    endtask

    task automatic t_hold();
        do_reset();
        wr(2'd0, 4'd6, KX, 2'd0);
        search(KX);
        wr(2'd0, 4'd6, KY, 2'd0);
        wr(2'd0, 4'd0, KX, 2'd0);
        cyc();
        cyc();
        chk("R4", "hit held", 64'(match_hit), 64'd1);
        chk("R4", "addr held", 64'(match_addr), 64'd6);
        search(KX);
        chk("R2", "new search picks entry 0", 64'(match_addr), 64'd0);
    endtask

    task automatic t_sources();
        do_reset();
        areg_wr = 1; areg_wdata = 4'd7;
        cyc();
        wr(2'd1, 4'd0, 64'hA7A7, 2'd0);
        rd(2'd0, 4'd7);
        chk("R7", "write via address register", rd_data, 64'hA7A7);
        rd(2'd1, 4'd0);
        chk("R10", "read via address register", rd_data, 64'hA7A7);
        wr(2'd0, 4'd11, KY, 2'd0);
        search(KY);
        wr(2'd3, 4'd0, 64'h5151, 2'd0);
        rd(2'd0, 4'd11);
        chk("R7", "write via match address", rd_data, 64'h5151);
        rd(2'd3, 4'd0);
        chk("R10", "read via match ok", 64'(rd_ok), 64'd1);
        chk("R10", "read via match data", rd_data, 64'h5151);
        wr(2'd2, 4'd9, 64'hF0F0, 2'd0);
        rd(2'd0, 4'd0);
        chk("R7", "write via next-free lands at 0", rd_data, 64'hF0F0);
        chk("R7", "next-free after write", 64'(nf_addr), 64'd1);
    endtask

    task automatic t_mask();
        do_reset();
        msk_wr = 1; msk_sel = 0; msk_wdata = 64'h0000_0000_FFFF_FFFF;
        cyc();
        msk_wr = 1; msk_sel = 1; msk_wdata = 64'hFFFF_FFFF_0000_0000;
        cyc();
        wr(2'd0, 4'd4, 64'h0123_4567_89AB_CDEF, 2'd0);
        wr(2'd0, 4'd4, 64'd0, 2'd1);
        rd(2'd0, 4'd4);
        chk("R8", "mask A keeps low half", rd_data, 64'h0000_0000_89AB_CDEF);
        wr(2'd0, 4'd4, '1, 2'd2);
        rd(2'd0, 4'd4);
        chk("R8", "mask B keeps high half", rd_data, 64'h0000_0000_FFFF_FFFF);
        wr(2'd0, 4'd4, 64'h5555_5555_5555_5555, 2'd3);
        rd(2'd0, 4'd4);
        chk("R8", "select 3 unmasked", rd_data, 64'h5555_5555_5555_5555);
        wr(2'd2, 4'd0, '1, 2'd1);
        rd(2'd0, 4'd0);
        chk("R8", "masked next-free write", rd_data, 64'hFFFF_FFFF_0000_0000);
    endtask

    task automatic t_ignore();
        do_reset();
        wr(2'd3, 4'd0, '1, 2'd0);
        chk("R9", "nf_addr after no-hit write", 64'(nf_addr), 64'd0);
        chk("R9", "full after no-hit write", 64'(full), 64'd0);
        rd(2'd0, 4'd0);
        chk("R9", "entry 0 untouched", rd_data, 64'd0);
        rd(2'd3, 4'd0);
        chk("R10", "no-hit read ok", 64'(rd_ok), 64'd0);
        chk("R10", "no-hit read data", rd_data, 64'd0);
    endtask

    task automatic t_same();
        do_reset();
        wr(2'd0, 4'd2, KX, 2'd0);
        wr_en = 1; wr_src = 2'd0; wr_addr = 4'd2; wr_data = KY; wr_msk = 2'd0;
        cmp_en = 1; cmp_data = KY;
        cyc();
        chk("R11", "search sees old word", 64'(match_hit), 64'd0);
        search(KY);
        chk("R11", "later search sees new word", 64'(match_hit), 64'd1);
        chk("R11", "later search addr", 64'(match_addr), 64'd2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_fill();
        t_priority();
        t_split();
        t_hold();
        t_sources();
        t_mask();
        t_ignore();
        t_same();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule